// File: doc/BRIEF.md
# Fan PWM Duty Generator

This block drives a set of fan output pins, one per channel, from one control byte per channel. Each control byte either pins its output high or lets a 64-step pulse-width modulator drive it. In PWM mode a six-bit duty code sets how many of the 64 steps are high, so the largest code still leaves one low step in every period. The control byte also holds a rate-select bit. It chooses which of two externally supplied tick-enable strobes advances that channel's step counter.

A per-channel doubling input lets a second, half-interval-offset strobe of the selected rate also advance the counter, which doubles the PWM frequency. A newly written duty code is held back until the step counter wraps to zero, so no period is ever cut short or stretched. The force-high bit and the rate bit act on the cycle after the write. Software-facing logic is limited to a write port and a combinational read port over the control bytes.

Top module: `fan_pwm_gen`

## Requirements
- R1: After reset every control byte reads 0x00, which means PWM mode with duty code 0 and rate 0, and every fan output is low.
- R2: A write with `wr_en` high stores `wr_data` into the control byte chosen by `wr_sel` on that clock edge, and `rd_data` then returns that byte for `rd_sel` equal to the same channel.
- R3: When bit 0 of a channel's control byte is 1, its output is high from the cycle after the write and stays high on every step, whatever the duty code.
- R4: When bit 0 is 0, the output is high while the channel's 6-bit step counter is below the active duty code, which is taken from bits 6:1. Over one 64-step period the output is high for exactly as many steps as the code, so code 0 keeps it low throughout.
- R5: Duty code 32 (control byte 0x40) gives 32 high steps out of 64.
- R6: Duty code 63 (control byte 0x7E) gives 63 high steps and one low step per 64-step period.
- R7: A duty code written mid-period has no effect on the output until the step counter passes from 63 to 0. From that step on, the new code applies.
- R8: Bit 7 of the control byte selects the step strobe: 0 selects `tick_lo` and 1 selects `tick_hi`. The strobe that is not selected does not advance the counter.
- R9: With `dbl[i]` high, the mid-interval strobe of the selected rate (`tick_lo_mid` or `tick_hi_mid`) also advances channel i's counter. With `dbl[i]` low, that strobe is ignored.
- R10: Channels are independent: a write to one channel changes neither another channel's control byte nor its output sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control byte write strobe |
| wr_sel | input | SELW | Channel written |
| wr_data | input | RW | Control byte value (RW = DW+2) |
| rd_sel | input | SELW | Channel read |
| rd_data | output | RW | Control byte of channel `rd_sel` |
| tick_lo | input | 1 | Base step strobe, rate 0 |
| tick_hi | input | 1 | Base step strobe, rate 1 |
| tick_lo_mid | input | 1 | Half-interval-offset strobe, rate 0 |
| tick_hi_mid | input | 1 | Half-interval-offset strobe, rate 1 |
| dbl | input | NCH | Per-channel frequency doubling enable |
| fan_o | output | NCH | Fan drive outputs |

## Verification
The in-RTL properties guard, on every cycle, the following behaviours:
- the step counter holds unless a selected strobe arrives, and moves by exactly one when one does;
- the active duty code changes only on a wrap;
- a zero code keeps the pin low, and the top code forces a low step at count 63;
- a forced channel is high;
- a write lands in the addressed byte.

Only the bench scenarios show period-level results:
- the high-step totals for several codes;
- the deferral of a mid-period duty change up to the wrap;
- the rejection of the wrong-rate and mid-interval strobes;
- that one channel's traffic leaves the other's sequence alone.

// File: rtl/fan_pwm_pkg.sv
package fan_pwm_pkg;
   // Fixed bit positions inside a control byte: force-high at the bottom,
   // duty field above it, rate select at the top.
   localparam int unsigned FORCE_POS = 0;
   localparam int unsigned DUTY_LSB  = 1;

   typedef enum logic {
      RATE_LO = 1'b0,
      RATE_HI = 1'b1
   } rate_e;

   function automatic int unsigned ctl_width(input int unsigned duty_w);
      return duty_w + 2;
   endfunction
endpackage

// File: rtl/fan_ctrl_regs.sv
module fan_ctrl_regs #(
   parameter int unsigned NCH  = 2,
   parameter int unsigned RW   = 8,
   parameter int unsigned SELW = 1
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     wr_en,
   input  logic [SELW-1:0]          wr_sel,
   input  logic [RW-1:0]            wr_data,
   input  logic [SELW-1:0]          rd_sel,
   output logic [RW-1:0]            rd_data,
   output logic [NCH-1:0][RW-1:0]   ctrl_o
);
   logic [NCH-1:0][RW-1:0] ctl_q;

   for (genvar g = 0; g < NCH; g++) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst)
            ctl_q[g] <= '0;
         else if (wr_en && (wr_sel == SELW'(g)))
            ctl_q[g] <= wr_data;
      end
   end

   always_comb begin
      rd_data = '0;
      for (int k = 0; k < NCH; k++)
         if (rd_sel == SELW'(k))
            rd_data = ctl_q[k];
   end

   assign ctrl_o = ctl_q;

   // R2
   wr_lands_chk: assert property (@(posedge clk) disable iff (rst)
      wr_en && (int'(wr_sel) < NCH) |=> ctl_q[$past(wr_sel)] == $past(wr_data));
endmodule

// File: rtl/fan_tick_sel.sv
module fan_tick_sel #(
   parameter bit ALLOW_DBL = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic rate_sel,
   input  logic dbl,
   input  logic tick_lo,
   input  logic tick_hi,
   input  logic tick_lo_mid,
   input  logic tick_hi_mid,
   output logic step_o
);
   import fan_pwm_pkg::*;

   logic base_t, mid_t;

   assign base_t = (rate_e'(rate_sel) == RATE_HI) ? tick_hi : tick_lo;

   if (ALLOW_DBL) begin : g_dbl
      assign mid_t = dbl & ((rate_e'(rate_sel) == RATE_HI) ? tick_hi_mid : tick_lo_mid);
   end else begin : g_nodbl
      logic unused_mid;
      assign unused_mid = dbl ^ tick_lo_mid ^ tick_hi_mid;
      assign mid_t = 1'b0;
   end

   assign step_o = base_t | mid_t;

   // R8
   lo_rate_ignores_hi_chk: assert property (@(posedge clk) disable iff (rst)
      !rate_sel && !tick_lo && !tick_lo_mid |-> !step_o);
   // R9
   no_dbl_ignores_mid_chk: assert property (@(posedge clk) disable iff (rst)
      !dbl && !tick_lo && !tick_hi |-> !step_o);
endmodule

// File: rtl/fan_pwm_core.sv
module fan_pwm_core #(
   parameter int unsigned DW = 6
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          step,
   input  logic [DW-1:0] duty_next,
   input  logic          force_hi,
   output logic          pwm_o
);
   localparam logic [DW-1:0] CNT_TOP = '1;

   logic [DW-1:0] cnt_q;
   logic [DW-1:0] act_q;
   logic          wrap;

   assign wrap = step && (cnt_q == CNT_TOP);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
         act_q <= '0;
      end else begin
         if (step)
            cnt_q <= cnt_q + 1'b1;
         if (wrap)
            act_q <= duty_next;
      end
   end

   assign pwm_o = force_hi | (cnt_q < act_q);

   // R4
   cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !step |=> $stable(cnt_q));
   // R4
   cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
      step |=> cnt_q == $past(cnt_q) + 1'b1);
   // R7
   duty_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !(step && cnt_q == CNT_TOP) |=> $stable(act_q));
   // R4
   zero_duty_chk: assert property (@(posedge clk) disable iff (rst)
      act_q == '0 && !force_hi |-> !pwm_o);
   // R6
   max_duty_low_chk: assert property (@(posedge clk) disable iff (rst)
      act_q == CNT_TOP && cnt_q == CNT_TOP && !force_hi |-> !pwm_o);
endmodule

// File: rtl/fan_pwm_gen.sv
module fan_pwm_gen #(
   parameter int unsigned NCH       = 2,
   parameter int unsigned DW        = 6,
   parameter bit          ALLOW_DBL = 1'b1,
   localparam int unsigned RW       = fan_pwm_pkg::ctl_width(DW),
   localparam int unsigned SELW     = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            wr_en,
   input  logic [SELW-1:0] wr_sel,
   input  logic [RW-1:0]   wr_data,
   input  logic [SELW-1:0] rd_sel,
   output logic [RW-1:0]   rd_data,
   input  logic            tick_lo,
   input  logic            tick_hi,
   input  logic            tick_lo_mid,
   input  logic            tick_hi_mid,
   input  logic [NCH-1:0]  dbl,
   output logic [NCH-1:0]  fan_o
);
   import fan_pwm_pkg::*;

   localparam int unsigned RATE_POS = DW + 1;

   initial begin
      nch_range_chk: assert (NCH >= 1 && NCH <= 64)
         else $error("NCH out of range");
      dw_range_chk: assert (DW >= 2 && DW <= 12)
         else $error("DW out of range");
   end

   logic [NCH-1:0][RW-1:0] ctrl;

   fan_ctrl_regs #(.NCH(NCH), .RW(RW), .SELW(SELW)) u_regs (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .rd_sel  (rd_sel),
      .rd_data (rd_data),
      .ctrl_o  (ctrl)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic step;

      fan_tick_sel #(.ALLOW_DBL(ALLOW_DBL)) u_tick (
         .clk         (clk),
         .rst         (rst),
         .rate_sel    (ctrl[c][RATE_POS]),
         .dbl         (dbl[c]),
         .tick_lo     (tick_lo),
         .tick_hi     (tick_hi),
         .tick_lo_mid (tick_lo_mid),
         .tick_hi_mid (tick_hi_mid),
         .step_o      (step)
      );

      fan_pwm_core #(.DW(DW)) u_core (
         .clk       (clk),
         .rst       (rst),
         .step      (step),
         .duty_next (ctrl[c][DUTY_LSB +: DW]),
         .force_hi  (ctrl[c][FORCE_POS]),
         .pwm_o     (fan_o[c])
      );

      // R3
      force_high_chk: assert property (@(posedge clk) disable iff (rst)
         wr_en && wr_sel == SELW'(c) && wr_data[FORCE_POS] |=> fan_o[c]);
   end
endmodule

// File: tb/fan_pwm_gen_bench.sv
`timescale 1ns/1ps
module fan_pwm_gen_bench;
   logic       clk = 1'b0;
   logic       rst;
   logic       wr_en;
   logic       wr_sel;
   logic [7:0] wr_data;
   logic       rd_sel;
   logic [7:0] rd_data;
   logic       tick_lo, tick_hi, tick_lo_mid, tick_hi_mid;
   logic [1:0] dbl;
   logic [1:0] fan_o;

   int tests = 0;
   int fails = 0;
   logic [7:0] ctl_m [2];
   int         bcnt  [2];

   always #5 clk = ~clk;

   fan_pwm_gen u_fan_pwm_gen (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .rd_sel(rd_sel), .rd_data(rd_data), .tick_lo(tick_lo), .tick_hi(tick_hi),
      .tick_lo_mid(tick_lo_mid), .tick_hi_mid(tick_hi_mid), .dbl(dbl), .fan_o(fan_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input int ch, input logic [7:0] v);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = ch[0]; wr_data = v;
      @(negedge clk);
      wr_en = 1'b0;
      ctl_m[ch] = v;
   endtask

   task automatic pulse(input logic lo, input logic hi, input logic mlo, input logic mhi);
      @(negedge clk);
      tick_lo = lo; tick_hi = hi; tick_lo_mid = mlo; tick_hi_mid = mhi;
      for (int c = 0; c < 2; c++) begin
         bit adv;
         adv = ctl_m[c][7] ? (hi | (dbl[c] & mhi)) : (lo | (dbl[c] & mlo));
         if (adv) bcnt[c] = (bcnt[c] + 1) % 64;
      end
      @(negedge clk);
      tick_lo = 0; tick_hi = 0; tick_lo_mid = 0; tick_hi_mid = 0;
   endtask

   task automatic step_ch(input int ch);
      if (ctl_m[ch][7]) pulse(0, 1, 0, 0);
      else              pulse(1, 0, 0, 0);
   endtask

   task automatic step_to(input int ch, input int target);
      while (bcnt[ch] != target) step_ch(ch);
   endtask

   task automatic load(input int ch);
      step_ch(ch);
      step_to(ch, 0);
   endtask

   task automatic measure(input int ch, output int hi);
      hi = 0;
      repeat (64) begin
         step_ch(ch);
         if (fan_o[ch]) hi++;
      end
   endtask

   task automatic t_reset();
      rst = 1'b1; wr_en = 0; wr_sel = 0; wr_data = 0; rd_sel = 0;
      tick_lo = 0; tick_hi = 0; tick_lo_mid = 0; tick_hi_mid = 0; dbl = 0;
      ctl_m[0] = 0; ctl_m[1] = 0; bcnt[0] = 0; bcnt[1] = 0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk(fan_o == 2'b00, "R1 outputs", fan_o, 0);
      rd_sel = 0; #1;
      chk(rd_data == 8'h00, "R1 ch0 reg", rd_data, 0);
      rd_sel = 1; #1;
      chk(rd_data == 8'h00, "R1 ch1 reg", rd_data, 0);
   endtask

   task automatic t_rdwr();
      wr(1, 8'hA5);
      rd_sel = 1; #1;
      chk(rd_data == 8'hA5, "R2 readback", rd_data, 8'hA5);
      rd_sel = 0; #1;
      chk(rd_data == 8'h00, "R10 other channel untouched", rd_data, 0);
      wr(1, 8'h00);
      load(1);
   endtask

   task automatic t_duty(input int code, input string req);
      int hi;
      wr(0, 8'(code << 1));
      load(0);
      measure(0, hi);
      chk(hi == code, req, hi, code);
   endtask

   task automatic t_force();
      int hi;
      step_to(0, 40);
      wr(0, 8'h01 | 8'(10 << 1));
      chk(fan_o[0] == 1'b1, "R3 immediate high", fan_o[0], 1);
      measure(0, hi);
      chk(hi == 64, "R3 forced whole period", hi, 64);
   endtask

   task automatic t_update();
      int hi = 0;
      wr(0, 8'h00);
      load(0);
      step_to(0, 10);
      wr(0, 8'(63 << 1));
      while (bcnt[0] != 63) begin
         step_ch(0);
         if (fan_o[0]) hi++;
      end
      chk(hi == 0, "R7 held until wrap", hi, 0);
      step_ch(0);
      chk(fan_o[0] == 1'b1, "R7 applied at wrap", fan_o[0], 1);
   endtask

   task automatic t_rate();
      wr(0, 8'h80 | 8'(32 << 1));
      load(0);
      step_to(0, 31);
      pulse(1, 0, 0, 0);
      chk(fan_o[0] == 1'b1, "R8 tick_lo ignored at rate 1", fan_o[0], 1);
      pulse(0, 1, 0, 0);
      chk(fan_o[0] == 1'b0, "R8 tick_hi steps at rate 1", fan_o[0], 0);
      wr(0, 8'(32 << 1));
      step_to(0, 31);
      pulse(0, 1, 0, 0);
      chk(fan_o[0] == 1'b1, "R8 tick_hi ignored at rate 0", fan_o[0], 1);
      pulse(1, 0, 0, 0);
      chk(fan_o[0] == 1'b0, "R8 tick_lo steps at rate 0", fan_o[0], 0);
   endtask

   task automatic t_double();
      step_to(0, 31);
      dbl = 2'b00;
      pulse(0, 0, 1, 0);
      chk(fan_o[0] == 1'b1, "R9 mid strobe ignored without doubling", fan_o[0], 1);
      dbl = 2'b01;
      pulse(0, 0, 1, 0);
      chk(fan_o[0] == 1'b0, "R9 mid strobe steps with doubling", fan_o[0], 0);
      pulse(0, 0, 0, 1);
      chk(fan_o[0] == 1'b0, "R9 other-rate mid strobe ignored", fan_o[0], 0);
   endtask

   task automatic t_indep();
      int hi;
      wr(1, 8'(16 << 1));
      wr(0, 8'h80 | 8'(48 << 1));
      load(1);
      load(0);
      measure(1, hi);
      chk(hi == 16, "R10 ch1 duty", hi, 16);
      measure(0, hi);
      chk(hi == 48, "R10 ch0 duty", hi, 48);
   endtask

   initial begin
      #2000000;
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      t_reset();
      t_rdwr();
      t_duty(0,  "R4 code 0");
      t_duty(5,  "R4 code 5");
      t_duty(32, "R5 code 32");
      t_duty(63, "R6 code 63");
      t_force();
      t_update();
      t_rate();
      t_double();
      t_indep();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule